// File: doc/BRIEF.md
# Serial Store-Path Float Denormalizer

This block sits on the store path of a floating-point unit whose register file holds every value, single or double, in double-precision layout. For a store-single it turns the 64-bit register image into the 32-bit memory image. Values in the single normal range, zeros, infinities, NaNs and values too large or too small for single format are converted in one cycle. Values that land in the single subnormal range need their mantissa moved right. This is done one bit per clock rather than with a barrel shifter, so the latency depends on the operand.

A second mode serves a store-double whose operand is a subnormal single value. Its fraction is shifted left one bit per clock until it is normalized, and the matching double exponent is built. The caller pulses `start` with `mode` and `operand`, and waits for the one-cycle `done` strobe. `busy` is high while a serial shift is under way.

Top module: `fpsd_store_denorm`

## Requirements
- R1: During and right after reset, `busy` and `done` are low and `result` is all zeros.
- R2: With `mode`=0 (store-single), an operand whose biased double exponent e lies in 897..1150 completes in one cycle. `result[31:0]` = {sign, e-896 as 8 bits, operand[51:29]} and `result[63:32]` = 0. This holds for every store-single result.
- R3: With `mode`=0, an operand with e = 0 or e below 874 completes in one cycle as a signed zero (sign in `result[31]`, all other bits 0).
- R4: With `mode`=0, an operand with e = 2047 (infinity or NaN) completes in one cycle as {sign, 8'hFF, operand[51:29]}.
- R5: With `mode`=0, an operand with e of 1151 or more completes in one cycle as a signed single infinity {sign, 8'hFF, 23'b0}.
- R6: With `mode`=0 and e in 874..896, the shift count is n = 897-e (1 to 23). The 24-bit mantissa {1, operand[51:29]} is shifted right n places with the bits lost truncated, and the result is {sign, 8'h00, shifted[22:0]}.
- R7: A serial operation of n shifts keeps `busy` high for exactly n consecutive cycles, never more than 23. `done` rises in the cycle in which `busy` falls, n+1 cycles after the start cycle. `busy` and `done` are never high together.
- R8: With `mode`=1 (store-double), the single image is `operand[31:0]` (bits 63:32 ignored). If its exponent field is 0 and its fraction f is nonzero with leading one at bit p, then n = 23-p shifts are made. The result is {sign, 897-n as 11 bits, (f shifted left n)[22:0], 29'b0}, with the timing of R7.
- R9: With `mode`=1, a zero single gives a signed double zero; an exponent field of 255 gives {sign, 11'h7FF, fraction, 29'b0}; any other nonzero exponent x gives {sign, x+896, fraction, 29'b0}. All of these take one cycle.
- R10: A `start` pulse while `busy` is high is ignored: the running operation's result and timing are unchanged and no extra `done` follows.
- R11: `done` is high for one clock per operation, and `result` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when `busy` is low |
| mode | input | 1 | 0 = store-single conversion, 1 = store-double restore of a subnormal single |
| operand | input | 64 | Register image (mode 1 reads bits 31:0) |
| busy | output | 1 | Serial shift in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Converted image (mode 0 in bits 31:0) |

## Verification
A start taken at one clock edge yields `done` and the result in the very next cycle for every one-cycle case. For a serial case of n shifts, `busy` is high for the n cycles after the start edge and `done` comes with the result in cycle n+1. The bench computes n and the expected image for each operand with its own arithmetic model. After every edge it samples `busy` and `done` against that cycle count, and it reads the result only in the cycle where `done` is due. One further cycle confirms that the strobe has dropped and the result is held. A start injected in the first busy cycle must leave that schedule and the result unchanged.

// File: rtl/fpsd_pkg.sv
// Package: shared field widths and exponent constants for the store-path
// denormalizer. Assumes IEEE-754 binary64 register images and binary32 memory images.
package fpsd_pkg;
    localparam int DEXP_W   = 11;
    localparam int DFRAC_W  = 52;
    localparam int SEXP_W   = 8;
    localparam int SFRAC_W  = 23;
    localparam int MANT_W   = SFRAC_W + 1;
    localparam int CNT_W    = $clog2(MANT_W + 1);
    localparam int DBIAS    = 1023;
    localparam int SBIAS    = 127;
    localparam int REBIAS   = DBIAS - SBIAS;          // 896
    localparam int DEN_LIM  = REBIAS + 1;             // 897
    localparam int OVF_EXP  = REBIAS + (1 << SEXP_W) - 1; // 1151
    localparam int MIN_SH   = DEN_LIM - MANT_W + 1;   // 874
    localparam int PAD_W    = DFRAC_W - SFRAC_W;      // 29

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DOUBLE = 1'b1
    } st_mode_e;
endpackage

// File: rtl/fpsd_classify.sv
// Module: fpsd_classify
// Decodes one operand. It either produces the finished one-cycle image, or it
// prepares the mantissa, the direction and the shift count for the serial unit.
// Assumes a purely combinational use in the cycle in which start is taken.
module fpsd_classify
    import fpsd_pkg::*;
(
    input  logic                mode,
    input  logic [63:0]         operand,
    output logic                fast,
    output logic [63:0]         fast_res,
    output logic                sign,
    output logic                dir_left,
    output logic [MANT_W-1:0]   mant_init,
    output logic [CNT_W-1:0]    cnt_init
);
    logic [DEXP_W-1:0]  d_exp;
    logic [SFRAC_W-1:0] d_frac;
    logic [SEXP_W-1:0]  s_exp;
    logic [SFRAC_W-1:0] s_frac;

    assign d_exp  = operand[62 -: DEXP_W];
    assign d_frac = operand[DFRAC_W-1 -: SFRAC_W];
    assign s_exp  = operand[30 -: SEXP_W];
    assign s_frac = operand[SFRAC_W-1:0];

    // Sort the operand into its path and build the one-cycle image.
    always_comb begin
        fast      = 1'b1;
        fast_res  = '0;
        dir_left  = 1'b0;
        mant_init = '0;
        cnt_init  = '0;
        sign      = (mode == MODE_DOUBLE) ? operand[31] : operand[63];
        if (mode == MODE_SINGLE) begin
            if (d_exp == '1) begin
                fast_res = {32'b0, sign, {SEXP_W{1'b1}}, d_frac};
            end else if (d_exp >= DEXP_W'(OVF_EXP)) begin
                fast_res = {32'b0, sign, {SEXP_W{1'b1}}, {SFRAC_W{1'b0}}};
            end else if (d_exp >= DEXP_W'(DEN_LIM)) begin
                fast_res = {32'b0, sign, SEXP_W'(d_exp - DEXP_W'(REBIAS)), d_frac};
            end else if (d_exp >= DEXP_W'(MIN_SH)) begin
                fast      = 1'b0;
                mant_init = {1'b1, d_frac};
                cnt_init  = CNT_W'(DEXP_W'(DEN_LIM) - d_exp);
            end else begin
                fast_res = {32'b0, sign, 31'b0};
            end
        end else begin
            if (s_exp == '1) begin
                fast_res = {sign, {DEXP_W{1'b1}}, s_frac, {PAD_W{1'b0}}};
            end else if (s_exp != '0) begin
                fast_res = {sign, DEXP_W'(s_exp) + DEXP_W'(REBIAS), s_frac, {PAD_W{1'b0}}};
            end else if (s_frac == '0) begin
                fast_res = {sign, 63'b0};
            end else begin
                fast      = 1'b0;
                dir_left  = 1'b1;
                mant_init = {1'b0, s_frac};
            end
        end
    end
endmodule

// File: rtl/fpsd_shift_unit.sv
// Module: fpsd_shift_unit
// Serial mantissa shifter that moves one bit per step. Right shifts stop after a
// loaded count; left shifts stop when the leading one reaches the top bit.
// Assumes load and step are never high together.
module fpsd_shift_unit
    import fpsd_pkg::*;
#(
    parameter int MW = MANT_W,
    parameter int CW = CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            dir_in,
    input  logic [MW-1:0]   mant_in,
    input  logic [CW-1:0]   cnt_in,
    output logic            last,
    output logic [MW-2:0]   frac_next,
    output logic [CW-1:0]   steps_next
);
    logic [MW-1:0] mant;
    logic [MW-1:0] mant_next;
    logic          dir_q;
    logic [CW-1:0] remain;
    logic [CW-1:0] steps;

    // Next mantissa, step total and end-of-run flag for the current step.
    always_comb begin
        mant_next  = dir_q ? (mant << 1) : (mant >> 1);
        steps_next = steps + CW'(1);
        last       = dir_q ? mant[MW-2] : (remain == CW'(1));
        frac_next  = mant_next[MW-2:0];
    end

    // Load a new mantissa or advance it by one bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant   <= '0;
            dir_q  <= 1'b0;
            remain <= '0;
            steps  <= '0;
        end else if (load) begin
            mant   <= mant_in;
            dir_q  <= dir_in;
            remain <= cnt_in;
            steps  <= '0;
        end else if (step) begin
            mant   <= mant_next;
            remain <= remain - CW'(1);
            steps  <= steps_next;
        end
    end
endmodule

// File: rtl/fpsd_store_denorm.sv
// Module: fpsd_store_denorm (top)
// Store-path converter. One-cycle cases finish at the start edge. Subnormal
// cases load the serial shifter and finish when it reports its last step.
// Assumes the caller holds operand and mode only in the start cycle.
module fpsd_store_denorm
    import fpsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode,
    input  logic [63:0] operand,
    output logic        busy,
    output logic        done,
    output logic [63:0] result
);
    logic                fast;
    logic [63:0]         fast_res;
    logic                sign;
    logic                dir_left;
    logic [MANT_W-1:0]   mant_init;
    logic [CNT_W-1:0]    cnt_init;
    logic                last;
    logic [SFRAC_W-1:0]  frac_next;
    logic [CNT_W-1:0]    steps_next;
    logic                accept;
    logic                mode_q;
    logic                sign_q;
    logic [63:0]         serial_res;

    fpsd_classify u_cls (
        .mode      (mode),
        .operand   (operand),
        .fast      (fast),
        .fast_res  (fast_res),
        .sign      (sign),
        .dir_left  (dir_left),
        .mant_init (mant_init),
        .cnt_init  (cnt_init)
    );

    fpsd_shift_unit #(.MW(MANT_W), .CW(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && !fast),
        .step       (busy),
        .dir_in     (dir_left),
        .mant_in    (mant_init),
        .cnt_in     (cnt_init),
        .last       (last),
        .frac_next  (frac_next),
        .steps_next (steps_next)
    );

    assign accept = start && !busy;

    // Format the final image of a serial run from the last shifter step.
    always_comb begin
        if (mode_q == MODE_DOUBLE)
            serial_res = {sign_q, DEXP_W'(DEN_LIM) - DEXP_W'(steps_next),
                          frac_next, {PAD_W{1'b0}}};
        else
            serial_res = {32'b0, sign_q, {SEXP_W{1'b0}}, frac_next};
    end

    // Control: take requests, run the serial phase, raise the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
            mode_q <= 1'b0;
            sign_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (last) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= serial_res;
                end
            end else if (start) begin
                mode_q <= mode;
                sign_q <= sign;
                if (fast) begin
                    result <= fast_res;
                    done   <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fpsd_checker.sv
// Module: fpsd_checker
// Protocol checks for fpsd_store_denorm, attached with bind.
// Assumes it sees only the top-level ports.
module fpsd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mode,
    input logic        busy,
    input logic        done,
    input logic [63:0] result
);
    logic [5:0] busy_run;
    logic       mode_seen;

    // Count consecutive busy cycles that came before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)           busy_run <= '0;
        else if (!busy)       busy_run <= '0;
        else if (busy_run != 6'h3F) busy_run <= busy_run + 6'd1;
    end

    // Remember the mode of the request that was taken last.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_seen <= 1'b0;
        else if (start && !busy) mode_seen <= mode;
    end

    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < 6'd23);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    a_r10_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start) || $past(busy)));

    a_r2_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_seen) |-> (result[63:32] == 32'b0));
endmodule

bind fpsd_store_denorm fpsd_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/fpsd_store_denorm_tb.sv
module fpsd_store_denorm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] operand = '0;
    logic        busy;
    logic        done;
    logic [63:0] result;
    int          n_checks = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    fpsd_store_denorm u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .operand(operand), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural reference: expected image and number of shift cycles.
    function automatic void model(input logic md, input logic [63:0] op,
                                  output logic [63:0] res, output int lat);
        int e;
        int n;
        logic [23:0] m;
        logic [22:0] f;
        lat = 0;
        res = '0;
        if (!md) begin
            e = int'(op[62:52]);
            f = op[51:29];
            if (e == 2047)      res = {32'b0, op[63], 8'hFF, f};
            else if (e >= 1151) res = {32'b0, op[63], 8'hFF, 23'b0};
            else if (e >= 897)  res = {32'b0, op[63], 8'(e - 896), f};
            else begin
                n = 897 - e;
                if (e == 0 || n > 23) res = {32'b0, op[63], 31'b0};
                else begin
                    m = {1'b1, f};
                    for (int i = 0; i < n; i++) m = m / 2;
                    res = {32'b0, op[63], 8'b0, m[22:0]};
                    lat = n;
                end
            end
        end else begin
            e = int'(op[30:23]);
            f = op[22:0];
            if (e == 255)     res = {op[31], 11'h7FF, f, 29'b0};
            else if (e != 0)  res = {op[31], 11'(e + 896), f, 29'b0};
            else if (f == 0)  res = {op[31], 63'b0};
            else begin
                m = {1'b0, f};
                n = 0;
                while (m < 24'h800000) begin m = m * 2; n++; end
                res = {op[31], 11'(897 - n), m[22:0], 29'b0};
                lat = n;
            end
        end
    endfunction

    // One request, compared against the model after every clock edge.
    task automatic run_op(input logic md, input logic [63:0] op, input string req, input bit inject);
        logic [63:0] exp_res;
        int lat;
        model(md, op, exp_res, lat);
        @(negedge clk);
        start = 1'b1; mode = md; operand = op;
        for (int c = 1; c <= lat + 1; c++) begin
            @(negedge clk);
            check({busy, done} == {1'(c <= lat), 1'(c == lat + 1)},
                  $sformatf("%s busy/done cycle %0d", req, c),
                  64'({busy, done}), 64'({1'(c <= lat), 1'(c == lat + 1)}));
            if (c == lat + 1) check(result == exp_res, {req, " result"}, result, exp_res);
            if (c == 1 && inject && lat > 0) begin
                start = 1'b1; mode = 1'b0; operand = 64'h3FF0000000000000; // R10 ignored start
            end else begin
                start = 1'b0;
            end
        end
        @(negedge clk);
        check(!done && result == exp_res, {req, " R11 strobe drop, result held"},
              {done, result[62:0]}, {1'b0, exp_res[62:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done} == 2'b00 && result == '0, "R1 reset state", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done} == 2'b00 && result == '0, "R1 after reset", result, 64'h0);
        run_op(1'b0, 64'h3FF0000000000000, "R2 one", 0);
        run_op(1'b0, 64'hBFF8000000000000, "R2 minus 1.5", 0);
        run_op(1'b0, 64'h47EFFFFFFFFFFFFF, "R2 top normal", 0);
        run_op(1'b0, 64'h8000000000000000, "R3 negative zero", 0);
        run_op(1'b0, 64'h000000000000FFFF, "R3 double subnormal", 0);
        run_op(1'b0, 64'hB690000000000000, "R3 flush e=873", 0);
        run_op(1'b0, 64'h7FF0000000000000, "R4 infinity", 0);
        run_op(1'b0, 64'h7FF8000000000001, "R4 NaN", 0);
        run_op(1'b0, 64'h47F0000000000000, "R5 overflow", 0);
        run_op(1'b0, 64'h380A000000000000, "R6 R7 e=896 one shift", 0);
        run_op(1'b0, 64'h375ABCDEF0123456, "R6 R7 e=885", 0);
        run_op(1'b0, 64'hB6A5555555555555, "R6 R7 e=874 23 shifts", 0);
        run_op(1'b1, 64'h0000000000400000, "R8 one shift", 0);
        run_op(1'b1, 64'h0000000080000001, "R8 23 shifts", 0);
        run_op(1'b1, 64'hFFFFFFFF00012345, "R8 mid fraction", 0);
        run_op(1'b1, 64'h0000000080000000, "R9 zero", 0);
        run_op(1'b1, 64'h000000003F800000, "R9 normal widen", 0);
        run_op(1'b1, 64'h000000007FC00000, "R9 NaN widen", 0);
        run_op(1'b0, 64'h375ABCDEF0123456, "R10 start while busy", 1);
        run_op(1'b1, 64'h0000000000000300, "R10 start while busy mode1", 1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule